// File: doc/BRIEF.md
# Call, Return and Jump Sequencer

This block is the control-transfer engine of an 8-bit processor with a 16-bit program counter. It owns the program counter and an 8-bit stack pointer. It also contains a private byte-wide stack memory of 256 entries, which it reads or writes one byte per cycle. When the fetch side presents an opcode together with the two bytes that follow it, the block works out the destination. For a call it first saves the return address on the stack, and for a return it restores the address from the stack. It then loads the program counter and raises `done` for one cycle.

Two kinds of target are handled. Long forms carry a full 16-bit address in the two following bytes, with the first of them holding the high half. Page-absolute forms carry an 11-bit target: bits 10..8 sit in the top three bits of the opcode and bits 7..0 are in the next byte. These 11 bits replace the low 11 bits of the program counter after it has been advanced past the instruction, and the upper 5 bits of that advanced value are kept. A return-from-interrupt behaves as a plain return and also clears a single in-service flag. The interrupt logic sets that flag through `isr_set`.

The controller moves through named states. IDLE accepts `start`. A call goes IDLE→PUSH_LO→PUSH_HI→IDLE. A return goes IDLE→POP_HI→POP_LO→POP_FIN→IDLE. A jump completes in IDLE itself. An opcode that is not recognised leaves the block in IDLE.

Top module: `call_ret_seq`

## Requirements
- R1: During and after reset, pc is 0x0000, sp is 0x07, and busy, done and in_service are all 0.
- R2: Opcode 0x02 (long jump) loads pc with {op_b2, op_b3}, with op_b2 as the high byte. done is high after the accepting clock edge, the stack is not touched and sp is unchanged.
- R3: An opcode whose low five bits are 00001 (absolute jump) loads pc with {(pc+2)[15:11], opcode[7:5], op_b2} after the accepting edge, with done high and sp unchanged.
- R4: Opcode 0x12 (long call) pushes the return address pc+3. The low byte is written at sp+1 on the first edge after acceptance and the high byte at sp+2 on the second edge, with sp rising by one at each of those edges. On that second edge pc becomes {op_b2, op_b3} and done rises.
- R5: An opcode whose low five bits are 10001 (absolute call) pushes pc+2 with the same timing as R4. pc then becomes {(pc+2)[15:11], opcode[7:5], op_b2}.
- R6: Opcode 0x22 (return) reads the high byte at sp, decrements sp, reads the low byte at the new sp, and decrements sp again. sp drops at the first and second edges after acceptance. pc is loaded from the two bytes with done high after the third edge after acceptance.
- R7: Opcode 0x32 (return from interrupt) follows R6 exactly and clears in_service in the same cycle that done is high. If isr_set is also high on that edge, the clear takes priority.
- R8: isr_set high on a clock edge makes in_service 1 after that edge.
- R9: start is ignored while busy is high. The running sequence completes as if start were low.
- R10: start with any other opcode is ignored: pc, sp and in_service keep their values and done stays low.
- R11: sp wraps modulo 256 on both push and pop, and no error is reported.
- R12: done is high for exactly one cycle per completed transfer and low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Opcode and operand bytes are valid; sampled only in IDLE |
| opcode | input | 8 | First instruction byte |
| op_b2 | input | 8 | Second instruction byte |
| op_b3 | input | 8 | Third instruction byte |
| isr_set | input | 1 | Marks an interrupt as in service |
| pc | output | 16 | Program counter |
| sp | output | 8 | Stack pointer |
| busy | output | 1 | A call or return sequence is in progress |
| done | output | 1 | One-cycle pulse when pc holds the new destination |
| in_service | output | 1 | Interrupt in-service flag |

## Verification
The assertions assume that `start` is only meaningful in IDLE, with operand bytes that are stable for that one cycle. They also assume that `isr_set` is never pulsed on the final edge of a return-from-interrupt. The stimulus drives `start` for a single cycle per instruction and waits until the model's expected cycles have drained before it issues the next one. The one exception is a deliberate mid-sequence pulse of `start` that checks R9. The bench only pops stack slots that it has filled, because the stack memory has no reset contents. Wrap-around is reached by nesting enough long calls to carry sp past 0xFF.

// File: rtl/crs_pkg.sv
package crs_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        K_NONE,
        K_LJMP,
        K_AJMP,
        K_LCALL,
        K_ACALL,
        K_RET,
        K_RETI
    } xfer_kind_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PUSH_LO,
        S_PUSH_HI,
        S_POP_HI,
        S_POP_LO,
        S_POP_FIN
    } seq_state_t;
endpackage

// File: rtl/crs_stack_ram.sv
module crs_stack_ram #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wdata;
        end
        rdata <= mem[addr];
    end
endmodule

// File: rtl/crs_decode.sv
module crs_decode
    import crs_pkg::*;
#(
    parameter int PC_W = 16
) (
    input  logic [7:0]      opcode,
    input  logic [7:0]      op_b2,
    input  logic [7:0]      op_b3,
    input  logic [PC_W-1:0] pc,
    output xfer_kind_t      kind,
    output logic [PC_W-1:0] target,
    output logic [PC_W-1:0] ret_addr
);
    localparam int PAGE_W = 11;
    localparam logic [PC_W-1:0] STEP2 = PC_W'(2);
    localparam logic [PC_W-1:0] STEP3 = PC_W'(3);

    logic [PC_W-1:0] pc_adv2;
    logic [PC_W-1:0] page_tgt;
    logic [PC_W-1:0] long_tgt;

    assign pc_adv2  = pc + STEP2;
    assign page_tgt = {pc_adv2[PC_W-1:PAGE_W], opcode[7:5], op_b2};
    assign long_tgt = {op_b2, op_b3};

    always_comb begin
        kind     = K_NONE;
        target   = long_tgt;
        ret_addr = pc_adv2;
        if (opcode == 8'h02) begin
            kind = K_LJMP;
        end else if (opcode == 8'h12) begin
            kind     = K_LCALL;
            ret_addr = pc + STEP3;
        end else if (opcode == 8'h22) begin
            kind = K_RET;
        end else if (opcode == 8'h32) begin
            kind = K_RETI;
        end else if (opcode[4:0] == 5'b00001) begin
            kind   = K_AJMP;
            target = page_tgt;
        end else if (opcode[4:0] == 5'b10001) begin
            kind   = K_ACALL;
            target = page_tgt;
        end
    end
endmodule

// File: rtl/call_ret_seq.sv
module call_ret_seq
    import crs_pkg::*;
#(
    parameter int PC_W     = 16,
    parameter int SP_W     = 8,
    parameter int SP_RESET = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [7:0]      opcode,
    input  logic [7:0]      op_b2,
    input  logic [7:0]      op_b3,
    input  logic            isr_set,
    output logic [PC_W-1:0] pc,
    output logic [SP_W-1:0] sp,
    output logic            busy,
    output logic            done,
    output logic            in_service
);
    localparam int HALF = PC_W / 2;
    localparam logic [SP_W-1:0] SP_ONE  = SP_W'(1);
    localparam logic [SP_W-1:0] SP_INIT = SP_W'(SP_RESET);

    seq_state_t state_q, state_n;
    xfer_kind_t kind;
    logic [PC_W-1:0] dec_target, dec_ret;
    logic [PC_W-1:0] pc_q, target_q, ret_q;
    logic [SP_W-1:0] sp_q;
    logic [HALF-1:0] hi_q;
    logic            done_q, insv_q, reti_q;
    logic            ram_we;
    logic [SP_W-1:0] ram_addr;
    logic [HALF-1:0] ram_wdata, ram_rdata;
    logic            is_call, is_ret, is_jump;

    crs_decode #(.PC_W(PC_W)) u_dec (
        .opcode  (opcode),
        .op_b2   (op_b2),
        .op_b3   (op_b3),
        .pc      (pc_q),
        .kind    (kind),
        .target  (dec_target),
        .ret_addr(dec_ret)
    );

    assign is_call = (kind == K_LCALL) || (kind == K_ACALL);
    assign is_ret  = (kind == K_RET)   || (kind == K_RETI);
    assign is_jump = (kind == K_LJMP)  || (kind == K_AJMP);

    assign ram_we    = (state_q == S_PUSH_LO) || (state_q == S_PUSH_HI);
    assign ram_addr  = ram_we ? (sp_q + SP_ONE) : sp_q;
    assign ram_wdata = (state_q == S_PUSH_LO) ? ret_q[HALF-1:0] : ret_q[PC_W-1:HALF];

    crs_stack_ram #(.AW(SP_W), .DW(HALF)) u_ram (
        .clk  (clk),
        .we   (ram_we),
        .addr (ram_addr),
        .wdata(ram_wdata),
        .rdata(ram_rdata)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_n;
    end

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (start && is_call)     state_n = S_PUSH_LO;
                else if (start && is_ret) state_n = S_POP_HI;
            end
            S_PUSH_LO: state_n = S_PUSH_HI;
            S_PUSH_HI: state_n = S_IDLE;
            S_POP_HI:  state_n = S_POP_LO;
            S_POP_LO:  state_n = S_POP_FIN;
            S_POP_FIN: state_n = S_IDLE;
            default:   state_n = S_IDLE;
        endcase
    end

    // Outputs and datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q     <= '0;
            sp_q     <= SP_INIT;
            target_q <= '0;
            ret_q    <= '0;
            hi_q     <= '0;
            done_q   <= 1'b0;
            insv_q   <= 1'b0;
            reti_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (isr_set) insv_q <= 1'b1;
            unique case (state_q)
                S_IDLE: begin
                    if (start) begin
                        target_q <= dec_target;
                        ret_q    <= dec_ret;
                        reti_q   <= (kind == K_RETI);
                        if (is_jump) begin
                            pc_q   <= dec_target;
                            done_q <= 1'b1;
                        end
                    end
                end
                S_PUSH_LO: sp_q <= sp_q + SP_ONE;
                S_PUSH_HI: begin
                    sp_q   <= sp_q + SP_ONE;
                    pc_q   <= target_q;
                    done_q <= 1'b1;
                end
                S_POP_HI: sp_q <= sp_q - SP_ONE;
                S_POP_LO: begin
                    sp_q <= sp_q - SP_ONE;
                    hi_q <= ram_rdata;
                end
                S_POP_FIN: begin
                    pc_q   <= {hi_q, ram_rdata};
                    done_q <= 1'b1;
                    if (reti_q) insv_q <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    assign pc         = pc_q;
    assign sp         = sp_q;
    assign busy       = (state_q != S_IDLE);
    assign done       = done_q;
    assign in_service = insv_q;

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R12
    AST_PUSH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |=> (sp == SP_W'($past(sp) + SP_ONE))); // R4
    AST_POP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_POP_HI || state_q == S_POP_LO) |=> (sp == SP_W'($past(sp) - SP_ONE))); // R6
    AST_JUMP_NO_STACK: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && is_jump) |=> ($stable(sp) && done && !busy)); // R2
    AST_BUSY_HOLDS_START: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_PUSH_LO) |=> (state_q == S_PUSH_HI)); // R9
    AST_RETI_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_POP_FIN && reti_q) |=> (!in_service && done)); // R7
    AST_UNKNOWN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && kind == K_NONE) |=> (!busy && !done && $stable(pc) && $stable(sp))); // R10
endmodule

// File: tb/call_ret_seq_bench.sv
`timescale 1ns/1ps
module call_ret_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  opcode = 8'h00, op_b2 = 8'h00, op_b3 = 8'h00;
    logic        isr_set = 1'b0;
    logic [15:0] pc;
    logic [7:0]  sp;
    logic        busy, done, in_service;

    always #2 clk = ~clk;

    call_ret_seq u_call_ret_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
        .op_b2(op_b2), .op_b3(op_b3), .isr_set(isr_set),
        .pc(pc), .sp(sp), .busy(busy), .done(done), .in_service(in_service)
    );

    int total = 0;
    int bad = 0;
    bit checking = 1'b0;
    bit finished = 1'b0;

    // Model state
    logic [15:0] m_pc = 16'h0000;
    logic [7:0]  m_sp = 8'h07;
    logic        m_insv = 1'b0;
    logic [7:0]  m_stk [256];
    logic [26:0] exp_q [$];
    string       tag_q [$];
    logic [26:0] last_exp;

    function automatic logic [26:0] pk(logic [15:0] p, logic [7:0] s,
                                       logic d, logic b, logic i);
        return {p, s, d, b, i};
    endfunction

    task automatic expect_cycle(logic [15:0] p, logic [7:0] s, logic d,
                                logic b, logic i, string t);
        exp_q.push_back(pk(p, s, d, b, i));
        tag_q.push_back(t);
    endtask

    // Per-clock comparison against the model
    always @(posedge clk) begin
        #1;
        if (checking) begin
            logic [26:0] e;
            logic [26:0] got;
            string t;
            if (exp_q.size() > 0) begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                last_exp = {e[26:3], 1'b0, e[1:0]};
            end else begin
                e = last_exp;
                t = "R12";
            end
            got = pk(pc, sp, done, busy, in_service);
            total++;
            if (got !== e) begin
                bad++;
                $display("FAIL %s: got pc=%h sp=%h done=%b busy=%b insv=%b expected pc=%h sp=%h done=%b busy=%b insv=%b",
                         t, got[26:11], got[10:3], got[2], got[1], got[0],
                         e[26:11], e[10:3], e[2], e[1], e[0]);
            end
        end
    end

    task automatic drain();
        while (exp_q.size() > 0) @(negedge clk);
    endtask

    task automatic issue(logic [7:0] op, logic [7:0] b2, logic [7:0] b3,
                         string t, bit poke);
        logic [15:0] p, tg, ra;
        logic [7:0]  s;
        @(negedge clk);
        p = m_pc;
        s = m_sp;
        opcode = op; op_b2 = b2; op_b3 = b3; start = 1'b1;
        if (op == 8'h02) begin
            tg = {b2, b3};
            expect_cycle(tg, s, 1'b1, 1'b0, m_insv, t);
            m_pc = tg;
        end else if (op == 8'h12 || op[4:0] == 5'b10001) begin
            if (op == 8'h12) begin
                ra = p + 16'd3;
                tg = {b2, b3};
            end else begin
                ra = p + 16'd2;
                tg = (ra & 16'hF800) | {5'b0, op[7:5], b2};
            end
            expect_cycle(p, s, 1'b0, 1'b1, m_insv, t);
            expect_cycle(p, s + 8'd1, 1'b0, 1'b1, m_insv, t);
            expect_cycle(tg, s + 8'd2, 1'b1, 1'b0, m_insv, t);
            m_stk[s + 8'd1] = ra[7:0];
            m_stk[s + 8'd2] = ra[15:8];
            m_sp = s + 8'd2;
            m_pc = tg;
        end else if (op == 8'h22 || op == 8'h32) begin
            tg = {m_stk[s], m_stk[s - 8'd1]};
            expect_cycle(p, s, 1'b0, 1'b1, m_insv, t);
            expect_cycle(p, s - 8'd1, 1'b0, 1'b1, m_insv, t);
            expect_cycle(p, s - 8'd2, 1'b0, 1'b1, m_insv, t);
            if (op == 8'h32) m_insv = 1'b0;
            expect_cycle(tg, s - 8'd2, 1'b1, 1'b0, m_insv, t);
            m_sp = s - 8'd2;
            m_pc = tg;
        end else if (op[4:0] == 5'b00001) begin
            ra = p + 16'd2;
            tg = (ra & 16'hF800) | {5'b0, op[7:5], b2};
            expect_cycle(tg, s, 1'b1, 1'b0, m_insv, t);
            m_pc = tg;
        end else begin
            expect_cycle(p, s, 1'b0, 1'b0, m_insv, t);
        end
        @(negedge clk);
        if (poke) begin
            // R9: start with a long jump while the sequence is running
            opcode = 8'h02; op_b2 = 8'hDE; op_b3 = 8'hAD; start = 1'b1;
            @(negedge clk);
        end
        start = 1'b0;
        drain();
    endtask

    task automatic raise_isr();
        @(negedge clk);
        isr_set = 1'b1;
        m_insv = 1'b1;
        expect_cycle(m_pc, m_sp, 1'b0, 1'b0, 1'b1, "R8");
        @(negedge clk);
        isr_set = 1'b0;
        drain();
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog: got hung run expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 256; k++) m_stk[k] = 8'h00;
        last_exp = pk(16'h0000, 8'h07, 1'b0, 1'b0, 1'b0);
        repeat (3) @(negedge clk);
        // R1: reset values held during reset
        total++;
        if ({pc, sp, busy, done, in_service} !== {16'h0000, 8'h07, 3'b000}) begin
            bad++;
            $display("FAIL R1: got pc=%h sp=%h b/d/i=%b%b%b expected pc=0000 sp=07 b/d/i=000",
                     pc, sp, busy, done, in_service);
        end
        rst_n = 1'b1;
        checking = 1'b1;
        repeat (2) @(negedge clk);

        issue(8'h02, 8'h12, 8'h34, "R2", 1'b0);      // long jump to 0x1234
        issue(8'h12, 8'h56, 8'h78, "R4", 1'b0);      // long call, ret 0x1237
        issue(8'hB1, 8'h22, 8'h00, "R5", 1'b0);      // absolute call -> 0x5522
        issue(8'h22, 8'h00, 8'h00, "R6", 1'b0);      // back to 0x567A
        issue(8'h22, 8'h00, 8'h00, "R6", 1'b0);      // back to 0x1237
        issue(8'h02, 8'h07, 8'hFE, "R2", 1'b0);
        issue(8'h61, 8'h99, 8'h00, "R3", 1'b0);      // page crossing -> 0x0B99
        issue(8'h02, 8'h07, 8'hFE, "R2", 1'b0);
        issue(8'hF1, 8'h01, 8'h00, "R5", 1'b0);      // -> 0x0F01, ret 0x0800
        raise_isr();
        issue(8'h32, 8'h00, 8'h00, "R7", 1'b0);      // back to 0x0800, flag cleared
        issue(8'h00, 8'h11, 8'h22, "R10", 1'b0);
        issue(8'hA5, 8'h11, 8'h22, "R10", 1'b0);
        issue(8'h12, 8'h30, 8'h00, "R9", 1'b1);      // start ignored mid-call
        issue(8'h22, 8'h00, 8'h00, "R9", 1'b1);      // start ignored mid-return
        // R11: nest calls until sp wraps past 0xFF, then unwind across it
        for (int n = 0; n < 126; n++) begin
            issue(8'h12, 8'h40, 8'h00, "R11", 1'b0);
        end
        for (int n = 0; n < 4; n++) begin
            issue(8'h22, 8'h00, 8'h00, "R11", 1'b0);
        end
        repeat (3) @(negedge clk);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule